// File: doc/BRIEF.md
# Main PLL Bring-Up Sequencer

This block is a hardware state machine that brings the primary clock PLL from reset to locked PLL mode with no software involved. A one-cycle start pulse captures the requested multiplier M, pre-divider D, output divider OD and a set of optional post-divider values. The block then issues an ordered series of register writes over a simple set/clear write bus. The bus reaches a PLL controller and its two configuration words. The block reads the controller's bypass flag once and polls its divider-update busy flag.

Every hold is counted on a free-running reference-clock counter, and each delay is a parameter in reference cycles. The bring-up is as follows. A stabilisation wait runs first. The outputs are then disabled, and a PLL found in bypass is also power cycled. The ratio fields are written next, followed by an aligned post-divider update. A reset pulse and a lock wait come after that, and the last step is the switch to PLL mode. A one-cycle done pulse closes each run.

Each bus write carries a register address, a clear mask and a set mask. The target register becomes `(old & ~clr) | set`.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, and whenever idle, `busy_o`, `done_o` and `wr_o` are low.
- R2: The first write is issued exactly T_STAB+1 cycles after the cycle in which start is sampled.
- R3: If `bypass_i` is high at the check, the writes run in this order. First, CFG1 (addr 6) sets bit 6. Second, CTL (addr 0) clears bits 0 and 5. Third, SEC (addr 1) sets bit 23. Fourth, CTL sets bit 1. Last, CTL clears bit 1, T_PD+1 cycles after bit 1 was set.
- R4: If `bypass_i` is low at the check, the only step before the ratio writes is the CTL write that clears bits 0 and 5.
- R5: The write that follows the enable-clearing CTL write comes T_HOLD+1 cycles after it.
- R6: The ratio fields are written as follows. CFG0 bits [18:6] get M-1, with clear mask 0x1FFF<<6. CFG0 bits [5:0] get D-1, with clear mask 0x3F. SEC bits [22:19] get OD-1, with clear mask 0xF<<19. The order is: M field, bandwidth low, bandwidth high, D field, OD field.
- R7: Let bw = (M-1)>>1. The low 8 bits of bw go to CFG0 bits [31:24], with clear mask 0xFF<<24. The upper bits of bw go to CFG1 bits [3:0], with clear mask 0xF.
- R8: Before the post-dividers are written, the busy flag is polled. Each poll follows a gap of T_POLL cycles. The block moves on at the first poll that sees the flag low, or after POLL_MAX polls.
- R9: Post-dividers are handled in ascending index order. Each enabled divider is written with clear mask 0xFFFFFFFF and set mask equal to its value with bit 15 set. Index i<3 goes to address 8+i; index i>=3 goes to address 16+(i-3). Disabled dividers are not written.
- R10: If any divider was written, ALN (addr 4) then sets the mask of written indices, and CMD (addr 3) sets bit 0. The block then polls busy again and only moves on after the flag is seen low. If no divider was written, both writes are skipped.
- R11: The final steps are as follows. CTL sets bit 3. T_RST+1 cycles later, CTL clears bit 3. T_LOCK+1 cycles after that, SEC clears bit 23. In the next cycle, CTL sets bit 0, and this is the last write.
- R12: `done_o` pulses for exactly one cycle, the cycle after the last write. `busy_o` is high from start until done. A start pulse while busy has no effect.
- R13: M, D, OD and the post-divider inputs are sampled only at start. Later changes do not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| mult_i | input | MW | Multiplier M |
| prediv_i | input | PREW | Pre-divider D |
| outdiv_i | input | ODW | Output divider OD |
| pdiv_val_i | input | NDIV*PDW | Post-divider values, index i at bits [i*PDW +: PDW] |
| pdiv_en_i | input | NDIV | Post-divider present flags |
| bypass_i | input | 1 | Controller reports bypass |
| go_busy_i | input | 1 | Controller divider-update busy |
| wr_o | output | 1 | Write strobe |
| addr_o | output | 6 | Register address |
| set_o | output | 32 | Bits to set |
| clr_o | output | 32 | Bits to clear |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The sequence is run four ways:
- starting in bypass, with a large multiplier;
- not in bypass, with a small ratio and a sparse divider set;
- with no dividers and the largest multiplier;
- with a busy flag stuck high.

Comparing the bypass and non-bypass logs separates the power-cycling branch from the short branch. The sparse divider set exercises both address ranges and the alignment mask. The divider-free run shows that the alignment and GO writes are skipped. The two poll runs distinguish an early exit from the POLL_MAX limit by their exact timing. A restart pulse and a changed multiplier injected mid-run show that neither has any effect.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  localparam int DATA_W = 32;
  localparam int AW     = 6;

  localparam logic [AW-1:0] A_CTL  = 6'd0;
  localparam logic [AW-1:0] A_SEC  = 6'd1;
  localparam logic [AW-1:0] A_CMD  = 6'd3;
  localparam logic [AW-1:0] A_ALN  = 6'd4;
  localparam logic [AW-1:0] A_CFG0 = 6'd5;
  localparam logic [AW-1:0] A_CFG1 = 6'd6;
  localparam logic [AW-1:0] A_DIVA = 6'd8;
  localparam logic [AW-1:0] A_DIVB = 6'd16;
  localparam int DIV_SPLIT = 3;

  localparam int CTL_PLLEN  = 0;
  localparam int CTL_PWRDN  = 1;
  localparam int CTL_RST    = 3;
  localparam int CTL_ENSRC  = 5;
  localparam int SEC_BYP    = 23;
  localparam int SEC_OD_LSB = 19;
  localparam int CFG0_D_LSB = 0;
  localparam int CFG0_M_LSB = 6;
  localparam int CFG0_BW_LSB = 24;
  localparam int CFG1_BW_LSB = 0;
  localparam int CFG1_ENSAT = 6;
  localparam int CMD_GO     = 0;
  localparam int DIV_EN     = 15;

  typedef enum logic [4:0] {
    S_IDLE, S_STAB, S_CHECK, S_CLR_EN, S_HOLD, S_SET_BYP, S_PWRDN, S_PD_WAIT,
    S_PWRUP, S_WR_M, S_WR_BWLO, S_WR_BWHI, S_WR_D, S_WR_OD, S_GAP, S_POLL,
    S_DIV, S_ALN, S_GO, S_RST_SET, S_RST_WAIT, S_RST_CLR, S_LOCK_WAIT,
    S_BYP_CLR, S_PLL_EN, S_DONE
  } seq_state_e;
endpackage

// File: rtl/pll_seq_timer.sv
`timescale 1ns/1ps
module pll_seq_timer #(
  parameter int TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  output logic [TW-1:0] elapsed_o
);
  logic [TW-1:0] cnt_q, mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mark_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (arm_i) mark_q <= cnt_q;
    end
  end

  // modular difference, one cycle after arming reads 1
  assign elapsed_o = cnt_q - mark_q;
endmodule

// File: rtl/pll_seq_fields.sv
`timescale 1ns/1ps
module pll_seq_fields
  import pll_seq_pkg::*;
#(
  parameter int MW     = 13,
  parameter int PREW   = 6,
  parameter int ODW    = 4,
  parameter int BWLO_W = 8
) (
  input  logic [MW-1:0]     mult_i,
  input  logic [PREW-1:0]   prediv_i,
  input  logic [ODW-1:0]    outdiv_i,
  output logic [DATA_W-1:0] m_set_o,
  output logic [DATA_W-1:0] m_clr_o,
  output logic [DATA_W-1:0] bwlo_set_o,
  output logic [DATA_W-1:0] bwlo_clr_o,
  output logic [DATA_W-1:0] bwhi_set_o,
  output logic [DATA_W-1:0] bwhi_clr_o,
  output logic [DATA_W-1:0] d_set_o,
  output logic [DATA_W-1:0] d_clr_o,
  output logic [DATA_W-1:0] od_set_o,
  output logic [DATA_W-1:0] od_clr_o
);
  localparam int BW_W   = MW - 1;
  localparam int BWHI_W = BW_W - BWLO_W;

  logic [MW-1:0]   m1;
  logic [BW_W-1:0] bw;
  logic [PREW-1:0] d1;
  logic [ODW-1:0]  od1;

  assign m1  = mult_i - 1'b1;
  assign bw  = m1[MW-1:1];
  assign d1  = prediv_i - 1'b1;
  assign od1 = outdiv_i - 1'b1;

  assign m_set_o    = DATA_W'(m1) << CFG0_M_LSB;
  assign m_clr_o    = DATA_W'({MW{1'b1}}) << CFG0_M_LSB;
  assign bwlo_set_o = DATA_W'(bw[BWLO_W-1:0]) << CFG0_BW_LSB;
  assign bwlo_clr_o = DATA_W'({BWLO_W{1'b1}}) << CFG0_BW_LSB;
  assign bwhi_set_o = DATA_W'(bw[BW_W-1:BWLO_W]) << CFG1_BW_LSB;
  assign bwhi_clr_o = DATA_W'({BWHI_W{1'b1}}) << CFG1_BW_LSB;
  assign d_set_o    = DATA_W'(d1) << CFG0_D_LSB;
  assign d_clr_o    = DATA_W'({PREW{1'b1}}) << CFG0_D_LSB;
  assign od_set_o   = DATA_W'(od1) << SEC_OD_LSB;
  assign od_clr_o   = DATA_W'({ODW{1'b1}}) << SEC_OD_LSB;
endmodule

// File: rtl/pll_seq_divmap.sv
`timescale 1ns/1ps
module pll_seq_divmap
  import pll_seq_pkg::*;
#(
  parameter int NDIV = 8,
  parameter int PDW  = 8,
  parameter int IW   = 3
) (
  input  logic [NDIV*PDW-1:0] val_i,
  input  logic [IW-1:0]       idx_i,
  output logic [AW-1:0]       addr_o,
  output logic [DATA_W-1:0]   data_o
);
  logic [AW-1:0]     addr_arr [NDIV];
  logic [DATA_W-1:0] data_arr [NDIV];

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    if (i < DIV_SPLIT) begin : g_lo
      assign addr_arr[i] = A_DIVA + AW'(i);
    end else begin : g_hi
      assign addr_arr[i] = A_DIVB + AW'(i - DIV_SPLIT);
    end
    assign data_arr[i] = DATA_W'(val_i[i*PDW +: PDW]) | (DATA_W'(1) << DIV_EN);
  end

  assign addr_o = addr_arr[idx_i];
  assign data_o = data_arr[idx_i];
endmodule

// File: rtl/pll_seq_top.sv
`timescale 1ns/1ps
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int MW       = 13,
  parameter int PREW     = 6,
  parameter int ODW      = 4,
  parameter int BWLO_W   = 8,
  parameter int NDIV     = 8,
  parameter int PDW      = 8,
  parameter int TW       = 24,
  parameter int T_STAB   = 2500,
  parameter int T_HOLD   = 4,
  parameter int T_PD     = 125,
  parameter int T_RST    = 175,
  parameter int T_LOCK   = 1250,
  parameter int T_POLL   = 12,
  parameter int POLL_MAX = 100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MW-1:0]       mult_i,
  input  logic [PREW-1:0]     prediv_i,
  input  logic [ODW-1:0]      outdiv_i,
  input  logic [NDIV*PDW-1:0] pdiv_val_i,
  input  logic [NDIV-1:0]     pdiv_en_i,
  input  logic                bypass_i,
  input  logic                go_busy_i,
  output logic                wr_o,
  output logic [5:0]          addr_o,
  output logic [31:0]         set_o,
  output logic [31:0]         clr_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int IW  = (NDIV > 1) ? $clog2(NDIV) : 1;
  localparam int PCW = $clog2(POLL_MAX + 1);

  seq_state_e state_q, state_d;
  logic byp_q, second_q;
  logic [PCW-1:0] poll_q;
  logic [IW-1:0] idx_q;
  logic [NDIV-1:0] aln_q;
  logic [MW-1:0] m_q;
  logic [PREW-1:0] d_q;
  logic [ODW-1:0] od_q;
  logic [NDIV*PDW-1:0] val_q;
  logic [NDIV-1:0] en_q;

  logic [TW-1:0] elapsed;
  logic arm, is_wait_d;

  logic [DATA_W-1:0] m_set, m_clr, bwlo_set, bwlo_clr, bwhi_set, bwhi_clr;
  logic [DATA_W-1:0] d_set, d_clr, od_set, od_clr, div_data;
  logic [AW-1:0] div_addr;

  pll_seq_timer #(.TW(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .elapsed_o(elapsed)
  );

  pll_seq_fields #(.MW(MW), .PREW(PREW), .ODW(ODW), .BWLO_W(BWLO_W)) u_fields (
    .mult_i(m_q), .prediv_i(d_q), .outdiv_i(od_q),
    .m_set_o(m_set), .m_clr_o(m_clr), .bwlo_set_o(bwlo_set), .bwlo_clr_o(bwlo_clr),
    .bwhi_set_o(bwhi_set), .bwhi_clr_o(bwhi_clr), .d_set_o(d_set), .d_clr_o(d_clr),
    .od_set_o(od_set), .od_clr_o(od_clr)
  );

  pll_seq_divmap #(.NDIV(NDIV), .PDW(PDW), .IW(IW)) u_divmap (
    .val_i(val_q), .idx_i(idx_q), .addr_o(div_addr), .data_o(div_data)
  );

  always_comb begin
    unique case (state_d)
      S_STAB, S_HOLD, S_PD_WAIT, S_GAP, S_RST_WAIT, S_LOCK_WAIT: is_wait_d = 1'b1;
      default: is_wait_d = 1'b0;
    endcase
  end
  assign arm = is_wait_d && (state_d != state_q);

  always_comb begin
    state_d = state_q;
    wr_o    = 1'b0;
    addr_o  = '0;
    set_o   = '0;
    clr_o   = '0;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_STAB;
      S_STAB:  if (elapsed >= TW'(T_STAB)) state_d = S_CHECK;
      S_CHECK: begin
        wr_o = 1'b1;
        if (bypass_i) begin
          addr_o  = A_CFG1;
          set_o   = DATA_W'(1) << CFG1_ENSAT;
          state_d = S_CLR_EN;
        end else begin
          addr_o  = A_CTL;
          clr_o   = (DATA_W'(1) << CTL_PLLEN) | (DATA_W'(1) << CTL_ENSRC);
          state_d = S_HOLD;
        end
      end
      S_CLR_EN: begin
        wr_o = 1'b1; addr_o = A_CTL;
        clr_o = (DATA_W'(1) << CTL_PLLEN) | (DATA_W'(1) << CTL_ENSRC);
        state_d = S_HOLD;
      end
      S_HOLD: if (elapsed >= TW'(T_HOLD)) state_d = byp_q ? S_SET_BYP : S_WR_M;
      S_SET_BYP: begin
        wr_o = 1'b1; addr_o = A_SEC; set_o = DATA_W'(1) << SEC_BYP; state_d = S_PWRDN;
      end
      S_PWRDN: begin
        wr_o = 1'b1; addr_o = A_CTL; set_o = DATA_W'(1) << CTL_PWRDN; state_d = S_PD_WAIT;
      end
      S_PD_WAIT: if (elapsed >= TW'(T_PD)) state_d = S_PWRUP;
      S_PWRUP: begin
        wr_o = 1'b1; addr_o = A_CTL; clr_o = DATA_W'(1) << CTL_PWRDN; state_d = S_WR_M;
      end
      S_WR_M: begin
        wr_o = 1'b1; addr_o = A_CFG0; set_o = m_set; clr_o = m_clr; state_d = S_WR_BWLO;
      end
      S_WR_BWLO: begin
        wr_o = 1'b1; addr_o = A_CFG0; set_o = bwlo_set; clr_o = bwlo_clr; state_d = S_WR_BWHI;
      end
      S_WR_BWHI: begin
        wr_o = 1'b1; addr_o = A_CFG1; set_o = bwhi_set; clr_o = bwhi_clr; state_d = S_WR_D;
      end
      S_WR_D: begin
        wr_o = 1'b1; addr_o = A_CFG0; set_o = d_set; clr_o = d_clr; state_d = S_WR_OD;
      end
      S_WR_OD: begin
        wr_o = 1'b1; addr_o = A_SEC; set_o = od_set; clr_o = od_clr; state_d = S_GAP;
      end
      S_GAP: if (elapsed >= TW'(T_POLL)) state_d = S_POLL;
      S_POLL: begin
        if (!go_busy_i || (!second_q && poll_q == PCW'(POLL_MAX - 1)))
          state_d = second_q ? S_RST_SET : S_DIV;
        else
          state_d = S_GAP;
      end
      S_DIV: begin
        if (en_q[idx_q]) begin
          wr_o = 1'b1; addr_o = div_addr; set_o = div_data; clr_o = '1;
        end
        if (idx_q == IW'(NDIV - 1)) state_d = S_ALN;
      end
      S_ALN: begin
        if (aln_q != '0) begin
          wr_o = 1'b1; addr_o = A_ALN; set_o = DATA_W'(aln_q); state_d = S_GO;
        end else begin
          state_d = S_RST_SET;
        end
      end
      S_GO: begin
        wr_o = 1'b1; addr_o = A_CMD; set_o = DATA_W'(1) << CMD_GO; state_d = S_GAP;
      end
      S_RST_SET: begin
        wr_o = 1'b1; addr_o = A_CTL; set_o = DATA_W'(1) << CTL_RST; state_d = S_RST_WAIT;
      end
      S_RST_WAIT: if (elapsed >= TW'(T_RST)) state_d = S_RST_CLR;
      S_RST_CLR: begin
        wr_o = 1'b1; addr_o = A_CTL; clr_o = DATA_W'(1) << CTL_RST; state_d = S_LOCK_WAIT;
      end
      S_LOCK_WAIT: if (elapsed >= TW'(T_LOCK)) state_d = S_BYP_CLR;
      S_BYP_CLR: begin
        wr_o = 1'b1; addr_o = A_SEC; clr_o = DATA_W'(1) << SEC_BYP; state_d = S_PLL_EN;
      end
      S_PLL_EN: begin
        wr_o = 1'b1; addr_o = A_CTL; set_o = DATA_W'(1) << CTL_PLLEN; state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      byp_q    <= 1'b0;
      second_q <= 1'b0;
      poll_q   <= '0;
      idx_q    <= '0;
      aln_q    <= '0;
      m_q      <= '0;
      d_q      <= '0;
      od_q     <= '0;
      val_q    <= '0;
      en_q     <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          m_q   <= mult_i;
          d_q   <= prediv_i;
          od_q  <= outdiv_i;
          val_q <= pdiv_val_i;
          en_q  <= pdiv_en_i;
          second_q <= 1'b0;
          idx_q    <= '0;
          aln_q    <= '0;
        end
        S_CHECK: byp_q <= bypass_i;
        S_WR_OD: poll_q <= '0;
        S_GO: begin
          poll_q   <= '0;
          second_q <= 1'b1;
        end
        S_POLL: poll_q <= poll_q + 1'b1;
        S_DIV: begin
          if (en_q[idx_q]) aln_q[idx_q] <= 1'b1;
          if (idx_q != IW'(NDIV - 1)) idx_q <= idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/pll_seq_chk.sv
`timescale 1ns/1ps
module pll_seq_chk
  import pll_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_o,
  input logic [5:0]  addr_o,
  input logic [31:0] set_o,
  input logic [31:0] clr_o,
  input logic        busy_o,
  input logic        done_o
);
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_o);

  a_r12_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r11_enable_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_o && addr_o == A_CTL && set_o[CTL_PLLEN]));

  a_r11_bypass_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && addr_o == A_CTL && set_o[CTL_PLLEN])
      |-> $past(wr_o && addr_o == A_SEC && clr_o[SEC_BYP]));

  a_r9_div_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && ((addr_o >= A_DIVA && addr_o < A_DIVA + 6'(DIV_SPLIT)) || addr_o >= A_DIVB))
      |-> set_o[DIV_EN]);
endmodule

bind pll_seq_top pll_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_o(wr_o), .addr_o(addr_o),
  .set_o(set_o), .clr_o(clr_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/pll_seq_top_tb.sv
`timescale 1ns/1ps
module pll_seq_top_tb;
  localparam int MW = 13, PREW = 6, ODW = 4, NDIV = 8, PDW = 8;
  localparam int T_STAB = 20, T_HOLD = 4, T_PD = 6, T_RST = 8, T_LOCK = 15;
  localparam int T_POLL = 3, POLL_MAX = 100;
  localparam int A_CTL = 0, A_SEC = 1, A_CMD = 3, A_ALN = 4, A_CFG0 = 5, A_CFG1 = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [MW-1:0] mult_i = '0;
  logic [PREW-1:0] prediv_i = '0;
  logic [ODW-1:0] outdiv_i = '0;
  logic [NDIV*PDW-1:0] pdiv_val_i = '0;
  logic [NDIV-1:0] pdiv_en_i = '0;
  logic bypass_i, go_busy_i;
  logic wr_o, busy_o, done_o;
  logic [5:0] addr_o;
  logic [31:0] set_o, clr_o;

  always #2 clk = ~clk;

  pll_seq_top #(
    .MW(MW), .PREW(PREW), .ODW(ODW), .NDIV(NDIV), .PDW(PDW),
    .T_STAB(T_STAB), .T_HOLD(T_HOLD), .T_PD(T_PD), .T_RST(T_RST),
    .T_LOCK(T_LOCK), .T_POLL(T_POLL), .POLL_MAX(POLL_MAX)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mult_i(mult_i),
    .prediv_i(prediv_i), .outdiv_i(outdiv_i), .pdiv_val_i(pdiv_val_i),
    .pdiv_en_i(pdiv_en_i), .bypass_i(bypass_i), .go_busy_i(go_busy_i),
    .wr_o(wr_o), .addr_o(addr_o), .set_o(set_o), .clr_o(clr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // controller model
  logic [31:0] regs [64];
  int busy_cnt = 0, go_len = 0, drop_cyc = -1;
  assign bypass_i  = regs[A_SEC][23];
  assign go_busy_i = (busy_cnt != 0);

  int n_log = 0, done_cnt = 0, done_cyc = -1;
  logic [5:0]  lg_addr [64];
  logic [31:0] lg_set [64], lg_clr [64];
  int          lg_cyc [64];

  always @(negedge clk) begin
    if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0) drop_cyc = cyc;
    end
    if (rst_ni && wr_o) begin
      if (n_log < 64) begin
        lg_addr[n_log] = addr_o; lg_set[n_log] = set_o;
        lg_clr[n_log] = clr_o; lg_cyc[n_log] = cyc;
      end
      n_log = n_log + 1;
      regs[addr_o] = (regs[addr_o] & ~clr_o) | set_o;
      if (addr_o == A_CMD && set_o[0]) busy_cnt = go_len;
    end
    if (rst_ni && done_o) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
  end

  // expected log
  int n_exp;
  logic [5:0]  ex_addr [64];
  logic [31:0] ex_set [64], ex_clr [64];
  string       ex_tag [64];
  int i_clren, i_pwrdn, i_od, i_rst;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add(input int a, input logic [31:0] s, input logic [31:0] c, input string t);
    ex_addr[n_exp] = 6'(a); ex_set[n_exp] = s; ex_clr[n_exp] = c; ex_tag[n_exp] = t;
    n_exp++;
  endtask

  task automatic build(input bit byp, input int m, input int d, input int od,
                       input logic [63:0] vals, input logic [7:0] en);
    int bw;
    logic [31:0] mask;
    n_exp = 0; mask = 0; bw = (m - 1) >> 1;
    if (byp) add(A_CFG1, 32'h40, 0, "R3");
    i_clren = n_exp;
    add(A_CTL, 0, 32'h21, byp ? "R3" : "R4");
    if (byp) begin
      add(A_SEC, 32'h0080_0000, 0, "R3");
      i_pwrdn = n_exp;
      add(A_CTL, 32'h2, 0, "R3");
      add(A_CTL, 0, 32'h2, "R3");
    end
    add(A_CFG0, 32'(m - 1) << 6, 32'h1FFF << 6, "R6");
    add(A_CFG0, 32'(bw & 8'hFF) << 24, 32'hFF << 24, "R7");
    add(A_CFG1, 32'((bw >> 8) & 4'hF), 32'hF, "R7");
    add(A_CFG0, 32'(d - 1), 32'h3F, "R6");
    i_od = n_exp;
    add(A_SEC, 32'(od - 1) << 19, 32'hF << 19, "R6");
    for (int i = 0; i < NDIV; i++) begin
      if (en[i]) begin
        add((i < 3) ? 8 + i : 16 + i - 3, {16'h0, 8'h80, vals[i*8 +: 8]}, 32'hFFFF_FFFF, "R9");
        mask[i] = 1'b1;
      end
    end
    if (mask != 0) begin
      add(A_ALN, mask, 0, "R10");
      add(A_CMD, 32'h1, 0, "R10");
    end
    i_rst = n_exp;
    add(A_CTL, 32'h8, 0, "R11");
    add(A_CTL, 0, 32'h8, "R11");
    add(A_SEC, 0, 32'h0080_0000, "R11");
    add(A_CTL, 32'h1, 0, "R11");
  endtask

  task automatic compare();
    chk(n_log == n_exp, "R9", "write count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(lg_addr[i] == ex_addr[i], ex_tag[i], $sformatf("addr of write %0d", i), lg_addr[i], ex_addr[i]);
      chk(lg_set[i] == ex_set[i], ex_tag[i], $sformatf("set of write %0d", i), lg_set[i], ex_set[i]);
      chk(lg_clr[i] == ex_clr[i], ex_tag[i], $sformatf("clr of write %0d", i), lg_clr[i], ex_clr[i]);
    end
  endtask

  int s_cyc;

  task automatic run(input bit byp, input int m, input int d, input int od,
                     input logic [63:0] vals, input logic [7:0] en,
                     input int pre_busy, input int glen, input bit poke);
    @(negedge clk);
    for (int i = 0; i < 64; i++) regs[i] = 0;
    regs[A_SEC][23] = byp;
    busy_cnt = pre_busy; go_len = glen; drop_cyc = -1;
    n_log = 0; done_cnt = 0; done_cyc = -1;
    mult_i = MW'(m); prediv_i = PREW'(d); outdiv_i = ODW'(od);
    pdiv_val_i = vals; pdiv_en_i = en;
    start_i = 1'b1; s_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy_o == 1'b1, "R12", "busy mid-run", busy_o, 1);
      start_i = 1'b1;
      mult_i = MW'(7); prediv_i = PREW'(5); pdiv_en_i = 8'hFF;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int k = 0; k < 20000 && done_cnt == 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    build(byp, m, d, od, vals, en);
    compare();
    if (n_log >= n_exp && n_exp > 0) begin
      chk(lg_cyc[0] - s_cyc == T_STAB + 1, "R2", "first write delay", lg_cyc[0] - s_cyc, T_STAB + 1);
      chk(lg_cyc[i_clren + 1] - lg_cyc[i_clren] == T_HOLD + 1, "R5", "hold after enable clear",
          lg_cyc[i_clren + 1] - lg_cyc[i_clren], T_HOLD + 1);
      if (byp)
        chk(lg_cyc[i_pwrdn + 1] - lg_cyc[i_pwrdn] == T_PD + 1, "R3", "power-down hold",
            lg_cyc[i_pwrdn + 1] - lg_cyc[i_pwrdn], T_PD + 1);
      chk(lg_cyc[i_rst + 1] - lg_cyc[i_rst] == T_RST + 1, "R11", "reset hold",
          lg_cyc[i_rst + 1] - lg_cyc[i_rst], T_RST + 1);
      chk(lg_cyc[i_rst + 2] - lg_cyc[i_rst + 1] == T_LOCK + 1, "R11", "lock wait",
          lg_cyc[i_rst + 2] - lg_cyc[i_rst + 1], T_LOCK + 1);
      chk(lg_cyc[i_rst + 3] - lg_cyc[i_rst + 2] == 1, "R11", "enable after bypass clear",
          lg_cyc[i_rst + 3] - lg_cyc[i_rst + 2], 1);
      chk(done_cyc == lg_cyc[n_log - 1] + 1, "R12", "done timing", done_cyc, lg_cyc[n_log - 1] + 1);
      if (en[0]) begin
        int gap_exp;
        gap_exp = (pre_busy > 1000) ? POLL_MAX * (T_POLL + 1) + 1 : T_POLL + 2;
        chk(lg_cyc[i_od + 1] - lg_cyc[i_od] == gap_exp, "R8", "poll exit timing",
            lg_cyc[i_od + 1] - lg_cyc[i_od], gap_exp);
      end
      if (en != 0)
        chk(drop_cyc >= 0 && lg_cyc[i_rst] > drop_cyc, "R10", "reset after busy cleared",
            lg_cyc[i_rst], drop_cyc);
    end
    chk(done_cnt == 1, "R12", "done pulse count", done_cnt, 1);
    chk(busy_o == 1'b0 && wr_o == 1'b0, "R1", "idle after done", {busy_o, wr_o}, 0);
  endtask

  task automatic test_reset();
    chk(busy_o == 0 && done_o == 0 && wr_o == 0, "R1", "reset outputs", {busy_o, done_o, wr_o}, 0);
  endtask

  // R4 R6 R7 R9 R10: no bypass, sparse dividers in both ranges
  task automatic test_plain();
    run(1'b0, 20, 2, 2, 64'h1122_3344_5566_7788, 8'b1001_0101, 0, 6, 1'b0);
  endtask

  // R3 R7: bypass path, bandwidth value spanning both words
  task automatic test_bypass();
    run(1'b1, 1000, 1, 9, 64'h0000_0000_0A00_0000, 8'b0000_1000, 0, 9, 1'b0);
  endtask

  // R10: no dividers, largest multiplier
  task automatic test_no_div();
    run(1'b0, 8191, 63, 15, 64'h0, 8'h00, 0, 0, 1'b0);
  endtask

  // R8: busy never clears before the post-dividers
  task automatic test_stuck_busy();
    run(1'b0, 40, 3, 4, 64'h0000_0000_0000_0042, 8'b0000_0001, 1000000, 5, 1'b0);
  endtask

  // R12 R13: restart pulse and input changes mid-run ignored
  task automatic test_ignore();
    run(1'b1, 64, 4, 2, 64'h0102_0304_0506_0708, 8'b1000_0011, 0, 4, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_plain();
    test_bypass();
    test_no_div();
    test_stuck_busy();
    test_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule